// File: doc/BRIEF.md
# CRC Channel Pattern and Sector Sequencer

This block is the control logic of a single CRC compression channel. Each valid data pattern is folded into a parallel signature register. A down counter tracks how many patterns remain in the current sector, and a free-running counter numbers the sectors. The channel has three operating modes, and each mode decides what happens at the end of a sector.

- **Checked mode:** the final signature is compared with an expected value. A DMA request is raised so that the next expected value can be loaded. On a mismatch, the number of the failing sector is latched.
- **Interrupt mode:** the channel pulses a compression-complete interrupt and makes no comparison.
- **Manual mode:** only the signature register runs. All counters and requests stay idle.

Software configures the channel through a small write port. The write address selects one of five targets:

| Address | Target | Data bits used |
|---|---|---|
| 0 | Mode | `wr_data[1:0]`: 0 = manual, 1 = checked, 2 = interrupt, 3 = manual |
| 1 | Pattern count | `wr_data[19:0]` |
| 2 | Sector counter preset | `wr_data[15:0]` |
| 3 | Expected signature | `wr_data[31:0]` |
| 4 | Fail-flag clear | data ignored |

A DMA controller answers each request by writing the expected-signature address, or by pulsing `dma_ack`.

Top module: `crc_chan_seq`

## Requirements
- R1: After reset, `sig_out` equals the seed 32'hFFFFFFFF. `dma_req`, `fail_irq`, `done_irq`, `sector_cnt` and `fail_sector` are all zero, and the channel is in manual mode.
- R2: Each cycle with `pat_valid` high, in any mode, the signature becomes ({sig[30:0],1'b0} ^ (sig[31] ? 32'h04C11DB7 : 0)) ^ pat_data. The new value is visible in the next cycle.
- R3: In checked and interrupt modes, a sector ends on the Nth valid pattern after the pattern counter is loaded, where N is the pattern count and a count of 0 acts as 1. The counter reloads in that same cycle, so the next sector starts with no gap. `sig_out` returns to the seed after the sector end.
- R4: In checked mode, the signature after the last pattern of a sector is compared with the expected value. On a mismatch, `fail_irq` goes high and `fail_sector` takes the number of the sector that just ended. On a match, neither output changes.
- R5: In checked and interrupt modes, `sector_cnt` increases by exactly one at each sector end. A write to address 2 presets it to `wr_data[15:0]`.
- R6: `fail_irq` is sticky. While it is high, `fail_sector` keeps the first failing sector even if later sectors fail. A write to address 4 clears `fail_irq`, after which the next failure is captured again.
- R7: In interrupt mode, each sector end produces a one-cycle `done_irq` pulse. No comparison is made and `fail_irq` never rises.
- R8: `dma_req` rises in the cycle after a checked-mode sector end. It then stays high until `dma_ack` is high or address 3 is written. It never rises in interrupt or manual mode.
- R9: In manual mode, `sector_cnt` does not move, and `done_irq`, `dma_req` and `fail_irq` never rise. The signature keeps accumulating past the pattern count and is never reseeded.
- R10: Writing the mode (address 0) or the pattern count (address 1) reloads the pattern counter and reseeds the signature, restarting the current sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| pat_valid | input | 1 | Data pattern valid |
| pat_data | input | 32 | Data pattern |
| dma_ack | input | 1 | DMA request acknowledge |
| dma_req | output | 1 | Request to refill the expected signature |
| done_irq | output | 1 | One-cycle compression-complete pulse |
| fail_irq | output | 1 | Sticky signature-mismatch flag |
| fail_sector | output | 16 | Number of the first failing sector |
| sector_cnt | output | 16 | Current sector number |
| sig_out | output | 32 | Current signature value |

## Verification
The hardest situation to reach from the ports is a second mismatch while the fail flag is still set. The stimulus must drive two complete sectors, each loaded with a deliberately wrong expected value, without clearing the flag in between. Only then can it show that the captured sector number does not move.

A directed sequence does this, then clears the flag and fails a third sector to confirm that capture resumes. A separate sequence rewrites the mode partway through a sector, so that the restart and reseed are seen before the sector could otherwise end.

// File: rtl/crc_seq_pkg.sv
package crc_seq_pkg;
    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_CHECK  = 2'd1,
        MODE_IRQ    = 2'd2,
        MODE_RSVD   = 2'd3
    } chan_mode_e;

    localparam int unsigned NUM_REGS = 5;
    localparam int unsigned REG_MODE = 0;
    localparam int unsigned REG_PCNT = 1;
    localparam int unsigned REG_SECT = 2;
    localparam int unsigned REG_EXP  = 3;
    localparam int unsigned REG_CLR  = 4;
endpackage

// File: rtl/crc_sig_step.sv
module crc_sig_step #(
    parameter int unsigned          SIG_W = 32,
    parameter logic [SIG_W-1:0]     POLY  = 32'h04C11DB7
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [SIG_W-1:0] data_in,
    output logic [SIG_W-1:0] sig_out
);
    logic [SIG_W-1:0] shifted;

    always_comb begin
        shifted = {sig_in[SIG_W-2:0], 1'b0};
        if (sig_in[SIG_W-1]) begin
            shifted = shifted ^ POLY;
        end
        sig_out = shifted ^ data_in;
    end
endmodule

// File: rtl/crc_reg_decode.sv
module crc_reg_decode #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned N_REGS = 5
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [N_REGS-1:0] strobe
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_strobe
        assign strobe[g] = wr_en && (wr_addr == ADDR_W'(g));
    end
endmodule

// File: rtl/crc_chan_seq.sv
module crc_chan_seq
    import crc_seq_pkg::*;
#(
    parameter int unsigned      SIG_W  = 32,
    parameter int unsigned      PAT_W  = 20,
    parameter int unsigned      SEC_W  = 16,
    parameter int unsigned      ADDR_W = 3,
    parameter logic [SIG_W-1:0] POLY   = 32'h04C11DB7,
    parameter logic [SIG_W-1:0] SEED   = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIG_W-1:0]  wr_data,
    input  logic              pat_valid,
    input  logic [SIG_W-1:0]  pat_data,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              done_irq,
    output logic              fail_irq,
    output logic [SEC_W-1:0]  fail_sector,
    output logic [SEC_W-1:0]  sector_cnt,
    output logic [SIG_W-1:0]  sig_out
);
    localparam logic [PAT_W-1:0] PAT_ONE = PAT_W'(1);
    localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);

    typedef struct packed {
        chan_mode_e       mode;
        logic [PAT_W-1:0] pat_load;
        logic [PAT_W-1:0] pat_left;
        logic [SEC_W-1:0] sector;
        logic [SEC_W-1:0] fail_sec;
        logic [SIG_W-1:0] sig;
        logic [SIG_W-1:0] expect_sig;
        logic             fail;
        logic             done;
        logic             req;
    } chan_state_t;

    chan_state_t         st_d, st_q;
    logic [NUM_REGS-1:0] wr_strobe;
    logic [SIG_W-1:0]    sig_next;
    logic                is_check, is_irq, counting, sector_end;
    logic [1:0]          mode_w;

    crc_sig_step #(.SIG_W(SIG_W), .POLY(POLY)) u_step (
        .sig_in  (st_q.sig),
        .data_in (pat_data),
        .sig_out (sig_next)
    );

    crc_reg_decode #(.ADDR_W(ADDR_W), .N_REGS(NUM_REGS)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strobe  (wr_strobe)
    );

    always_comb begin
        is_check   = (st_q.mode == MODE_CHECK);
        is_irq     = (st_q.mode == MODE_IRQ);
        counting   = is_check || is_irq;
        sector_end = pat_valid && counting && (st_q.pat_left <= PAT_ONE);

        st_d      = st_q;
        st_d.done = 1'b0;

        if (dma_ack) begin
            st_d.req = 1'b0;
        end

        if (pat_valid) begin
            st_d.sig = sig_next;
            if (counting) begin
                if (sector_end) begin
                    st_d.pat_left = st_q.pat_load;
                    st_d.sig      = SEED;
                    st_d.sector   = st_q.sector + SEC_ONE;
                    if (is_check) begin
                        st_d.req = 1'b1;
                        if ((sig_next != st_q.expect_sig) && !st_q.fail) begin
                            st_d.fail     = 1'b1;
                            st_d.fail_sec = st_q.sector;
                        end
                    end else begin
                        st_d.done = 1'b1;
                    end
                end else begin
                    st_d.pat_left = st_q.pat_left - PAT_ONE;
                end
            end
        end

        if (wr_strobe[REG_MODE]) begin
            st_d.mode     = chan_mode_e'(wr_data[1:0]);
            st_d.pat_left = st_q.pat_load;
            st_d.sig      = SEED;
        end
        if (wr_strobe[REG_PCNT]) begin
            st_d.pat_load = wr_data[PAT_W-1:0];
            st_d.pat_left = wr_data[PAT_W-1:0];
            st_d.sig      = SEED;
        end
        if (wr_strobe[REG_SECT]) begin
            st_d.sector = wr_data[SEC_W-1:0];
        end
        if (wr_strobe[REG_EXP]) begin
            st_d.expect_sig = wr_data;
            st_d.req        = 1'b0;
        end
        if (wr_strobe[REG_CLR]) begin
            st_d.fail = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.mode       <= MODE_MANUAL;
            st_q.pat_load   <= PAT_ONE;
            st_q.pat_left   <= PAT_ONE;
            st_q.sig        <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_w      = st_q.mode;
    assign dma_req     = st_q.req;
    assign done_irq    = st_q.done;
    assign fail_irq    = st_q.fail;
    assign fail_sector = st_q.fail_sec;
    assign sector_cnt  = st_q.sector;
    assign sig_out     = st_q.sig;
endmodule

// File: rtl/crc_chan_seq_chk.sv
module crc_chan_seq_chk #(
    parameter int unsigned SEC_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              dma_ack,
    input logic [1:0]        mode_q,
    input logic              dma_req,
    input logic              done_irq,
    input logic              fail_irq,
    input logic [SEC_W-1:0]  fail_sector,
    input logic [SEC_W-1:0]  sector_cnt
);
    logic manual_q;
    assign manual_q = (mode_q != 2'd1) && (mode_q != 2'd2);

    // R6: captured sector is frozen while the flag stays up
    a_r6_first_fail_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_irq && !(wr_en && wr_addr == ADDR_W'(4))) |=> (fail_irq && $stable(fail_sector)));

    // R7: completion pulse only follows interrupt mode
    a_r7_done_from_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> ($past(mode_q) == 2'd2));

    // R8: request held until acknowledge or refill write
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !(wr_en && wr_addr == ADDR_W'(3))) |=> dma_req);

    // R8: no request outside checked mode
    a_r8_req_only_checked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'd1 && !dma_req) |=> !dma_req);

    // R9: manual mode freezes the sector number and raises nothing
    a_r9_manual_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (manual_q && !wr_en) |=> ($stable(sector_cnt) && !done_irq && $stable(fail_irq)));

    // R5: sector number moves by at most one without a preset write
    a_r5_sector_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ((sector_cnt == $past(sector_cnt)) ||
                      (sector_cnt == $past(sector_cnt) + SEC_W'(1))));
endmodule

bind crc_chan_seq crc_chan_seq_chk #(.SEC_W(SEC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .dma_ack     (dma_ack),
    .mode_q      (mode_w),
    .dma_req     (dma_req),
    .done_irq    (done_irq),
    .fail_irq    (fail_irq),
    .fail_sector (fail_sector),
    .sector_cnt  (sector_cnt)
);

// File: tb/sim_crc_chan_seq.sv
`timescale 1ns/1ps
module sim_crc_chan_seq;
    localparam logic [31:0] SEED = 32'hFFFFFFFF;
    localparam logic [31:0] POLY = 32'h04C11DB7;
    localparam logic [31:0] STEP = 32'h9E3779B9;

    // vector: [42:41] mode, [40:33] pattern count, [32:1] base data, [0] wrong expected
    localparam int NVEC = 6;
    localparam logic [42:0] VEC [NVEC] = '{
        {2'd1, 8'd4, 32'h12345678, 1'b0},
        {2'd1, 8'd3, 32'hCAFEF00D, 1'b1},
        {2'd2, 8'd5, 32'h0BADBEEF, 1'b0},
        {2'd1, 8'd1, 32'h00000001, 1'b0},
        {2'd2, 8'd2, 32'hFFFFFFFF, 1'b1},
        {2'd1, 8'd7, 32'h55AA55AA, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pat_valid = 1'b0;
    logic [31:0] pat_data = '0;
    logic        dma_ack = 1'b0;
    logic        dma_req, done_irq, fail_irq;
    logic [15:0] fail_sector, sector_cnt;
    logic [31:0] sig_out;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    crc_chan_seq u0 (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pat_valid, .pat_data,
        .dma_ack, .dma_req, .done_irq, .fail_irq, .fail_sector, .sector_cnt, .sig_out
    );

    function automatic logic [31:0] fold(input logic [31:0] s, input logic [31:0] d);
        logic [31:0] t;
        t = {s[30:0], 1'b0};
        if (s[31]) t = t ^ POLY;
        return t ^ d;
    endfunction

    function automatic logic [31:0] sector_sig(input logic [31:0] base, input int n);
        logic [31:0] s;
        s = SEED;
        for (int k = 0; k < n; k++) s = fold(s, base + STEP * k);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic [31:0] d);
        pat_valid = 1'b1; pat_data = d;
        @(negedge clk);
        pat_valid = 1'b0;
    endtask

    task automatic ack();
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [15:0] pre;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(sig_out == SEED, "R1 sig", sig_out, SEED);
        check({dma_req, fail_irq, done_irq} == 3'b000, "R1 flags", {dma_req, fail_irq, done_irq}, 0);
        check(sector_cnt == 0 && fail_sector == 0, "R1 sectors", {sector_cnt, fail_sector}, 0);

        // table of sectors
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  m;
            int          n;
            logic [31:0] b, good;
            logic        wrong;
            m = VEC[i][42:41]; n = int'(VEC[i][40:33]); b = VEC[i][32:1]; wrong = VEC[i][0];
            pre = 16'(i * 16 + 3);
            wr(3'd4, 0);
            if (dma_req) ack();
            check(!dma_req, "R8 ack clears", dma_req, 0);
            wr(3'd0, {30'd0, m});
            wr(3'd1, n);
            wr(3'd2, {16'd0, pre});
            good = sector_sig(b, n);
            wr(3'd3, good ^ {31'd0, wrong});
            for (int k = 0; k < n - 1; k++) push(b + STEP * k);
            s = sector_sig(b, n - 1);
            check(sig_out == s, "R2 partial sig", sig_out, s);
            check(sector_cnt == pre, "R3 no early end", sector_cnt, pre);
            push(b + STEP * (n - 1));
            check(sig_out == SEED, "R3 reseed", sig_out, SEED);
            check(sector_cnt == pre + 16'd1, "R5 sector step", sector_cnt, pre + 16'd1);
            if (m == 2'd1) begin
                check(dma_req, "R8 request", dma_req, 1);
                check(fail_irq == wrong, "R4 compare", fail_irq, wrong);
                if (wrong) check(fail_sector == pre, "R4 fail sector", fail_sector, pre);
            end else begin
                check(done_irq, "R7 done", done_irq, 1);
                check(!dma_req && !fail_irq, "R7 no compare", {dma_req, fail_irq}, 0);
            end
            @(negedge clk);
            check(!done_irq, "R7 one cycle", done_irq, 0);
        end

        // R8 held, then cleared by expected-value write
        wr(3'd4, 0);
        wr(3'd0, 1);
        wr(3'd1, 2);
        wr(3'd3, sector_sig(32'h1, 2));
        push(32'h1); push(32'h1 + STEP);
        repeat (3) @(negedge clk);
        check(dma_req, "R8 held", dma_req, 1);
        wr(3'd3, 0);
        check(!dma_req, "R8 refill clears", dma_req, 0);

        // R6 first failure retained, clear re-arms
        wr(3'd2, 100);
        wr(3'd3, 32'hDEAD0000);
        push(32'h5); push(32'h6);
        check(fail_irq && fail_sector == 100, "R6 first capture", fail_sector, 100);
        wr(3'd3, 32'hDEAD0001);
        push(32'h7); push(32'h8);
        check(fail_irq && fail_sector == 100, "R6 kept first", fail_sector, 100);
        wr(3'd4, 0);
        check(!fail_irq, "R6 cleared", fail_irq, 0);
        wr(3'd3, 32'hDEAD0002);
        push(32'h9); push(32'hA);
        check(fail_irq && fail_sector == 102, "R6 recapture", fail_sector, 102);
        ack();

        // R9 manual mode: no reseed, no counting
        wr(3'd4, 0);
        wr(3'd0, 0);
        pre = sector_cnt;
        push(32'h11); push(32'h22); push(32'h33);
        s = fold(fold(fold(SEED, 32'h11), 32'h22), 32'h33);
        check(sig_out == s, "R9 accumulates", sig_out, s);
        check(sector_cnt == pre, "R9 sector frozen", sector_cnt, pre);
        check({dma_req, done_irq, fail_irq} == 0, "R9 quiet", {dma_req, done_irq, fail_irq}, 0);

        // R10 mode rewrite restarts the sector
        wr(3'd0, 2);
        wr(3'd1, 3);
        push(32'h44);
        wr(3'd0, 2);
        check(sig_out == SEED, "R10 reseed", sig_out, SEED);
        push(32'h1); push(32'h2);
        check(!done_irq, "R10 restart count", done_irq, 0);
        push(32'h3);
        check(done_irq, "R10 end after reload", done_irq, 1);

        // R3 count of zero acts as one
        wr(3'd1, 0);
        pre = sector_cnt;
        push(32'h77);
        check(done_irq && sector_cnt == pre + 16'd1, "R3 zero count", sector_cnt, pre + 16'd1);
        push(32'h78);
        check(done_irq, "R3 back-to-back", done_irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule